// File: doc/BRIEF.md
# Load-Pair Execution Unit (Non-Temporal)

This unit executes one load-pair instruction at a time. It takes a 32-bit instruction word over a valid/ready input and checks the opcode pattern. It reads the base register through a register-file port, or uses the stack pointer, and adds a signed 7-bit immediate scaled by the element size. It then fetches two elements from memory and returns them through two register write ports that fire in the same cycle.

The element size is 32 or 64 bits. A build option sets the memory traffic: either one read of twice the element width, or two reads of one element each, back to back. In the wide mode a big-endian control input swaps which half of the returned data goes to which destination.

Faults are reported on a single exception output with a 2-bit cause, and no register is written when a fault is raised. The causes are: a pattern mismatch, a reserved size code, a misaligned stack pointer and a bus error. A build option chooses how the unit handles an instruction whose two destinations are the same register. Every memory request carries a streaming-hint sideband bit.

Top module: `lp_pair_unit`

## Requirements
- R1: An accepted word whose bits [29:22] differ from 8'b1010_0001 raises exc_code 0 (mismatch) on exc_valid in the cycle after acceptance. It issues no memory request and no register write.
- R2: A matching word with bit 30 set (reserved size code) raises exc_code 1 (undefined) in the cycle after acceptance, with no memory request and no write.
- R3: Bit 31 selects the element size: 0 gives 32 bits, 1 gives 64 bits. The effective address is the base plus imm7 (bits [21:15]), sign-extended and shifted left by 2 for 32-bit elements or by 3 for 64-bit elements.
- R4: Bits [9:5] name the base register. Index 31 selects sp_value. Any other index selects rf_rd_data, which is read at rf_rd_idx = bits [9:5] in the acceptance cycle.
- R5: A stack-pointer base with any of its low four bits set raises exc_code 2 (alignment), with no memory request and no write.
- R6: When the two destinations (bits [4:0] and bits [14:10]) are equal, the policy parameter OVL applies. OVL=0 loads normally and writes zero to both ports. OVL=1 raises exc_code 1. OVL=2 does nothing: no request, no write and no exception.
- R7: With WIDE=1 one request is issued at the effective address. Its mem_req_size (log2 of bytes) is 3 for 32-bit elements and 4 for 64-bit elements. With big_endian=0, the low element goes to write port 0 (index bits [4:0]) and the high element goes to write port 1 (index bits [14:10]).
- R8: With WIDE=1 and big_endian=1 the two halves are exchanged between the write ports.
- R9: With WIDE=0 two requests are issued, of size 2 or 3. The first is at the effective address and the second at that address plus the element size in bytes. The first result goes to port 0 and the second to port 1, whatever big_endian is. A request is held stable until accepted.
- R10: A 32-bit element is zero-extended to 64 bits on its write port.
- R11: Both write enables pulse together for one cycle, in the cycle directly after the final error-free response.
- R12: A response with mem_rsp_err set suppresses both writes and raises exc_code 3 (data abort) in the following cycle. In split mode an error on the second read also discards the first result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit idle and able to accept |
| in_insn | input | 32 | Instruction word |
| big_endian | input | 1 | Selects big-endian data placement |
| rf_rd_idx | output | 5 | Register-file read index (base field) |
| rf_rd_data | input | 64 | Register-file read data, same cycle |
| sp_value | input | AW (64) | Current stack pointer |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW (64) | Request byte address |
| mem_req_size | output | 3 | log2 of request bytes |
| mem_req_nt | output | 1 | Streaming (non-temporal) hint, always set |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | 128 | Response data, byte 0 in the low bits |
| mem_rsp_err | input | 1 | Response carries a bus error |
| wr0_en | output | 1 | First destination write enable |
| wr0_idx | output | 5 | First destination index |
| wr0_data | output | 64 | First destination data |
| wr1_en | output | 1 | Second destination write enable |
| wr1_idx | output | 5 | Second destination index |
| wr1_data | output | 64 | Second destination data |
| exc_valid | output | 1 | Exception pulse |
| exc_code | output | 2 | 0 mismatch, 1 undefined, 2 alignment, 3 data abort |

## Verification
In split mode, a bus error on the second read lands in the cycle that would otherwise commit the write-back of both elements. The abort path and the commit path therefore contend in one cycle. The bench provokes this by placing the base so that the first element sits just below an error window and the second falls inside it. The outcome is judged on three counts: two requests appear, a data abort is flagged, and neither write port fires. The same stimulus sent to the wide build must commit normally.

// File: rtl/lp_pkg.sv
package lp_pkg;

  localparam int XLEN = 64;

  // fixed opcode pattern in bits [29:22]
  localparam logic [7:0] OP_PATTERN = 8'b1010_0001;

  // destination-overlap policies
  localparam logic [1:0] OVL_ZERO  = 2'd0;
  localparam logic [1:0] OVL_UNDEF = 2'd1;
  localparam logic [1:0] OVL_NOP   = 2'd2;

  typedef enum logic [1:0] {
    EXC_NOMATCH = 2'd0,
    EXC_UNDEF   = 2'd1,
    EXC_ALIGN   = 2'd2,
    EXC_ABORT   = 2'd3
  } exc_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ0,
    ST_WAIT0,
    ST_REQ1,
    ST_WAIT1
  } st_e;

  typedef struct packed {
    logic       match;
    logic       undef;
    logic       dbl;
    logic [6:0] imm7;
    logic [4:0] rt2;
    logic [4:0] rn;
    logic [4:0] rt;
  } dec_t;

endpackage

// File: rtl/lp_decode.sv
module lp_decode
  import lp_pkg::*;
(
  input  logic [31:0] insn,
  output dec_t        dec
);

  always_comb begin
    dec.match = (insn[29:22] == OP_PATTERN);
    dec.undef = insn[30];
    dec.dbl   = insn[31];
    dec.imm7  = insn[21:15];
    dec.rt2   = insn[14:10];
    dec.rn    = insn[9:5];
    dec.rt    = insn[4:0];
  end

endmodule

// File: rtl/lp_agen.sv
module lp_agen #(
  parameter int AW = 64
) (
  input  logic [AW-1:0] gpr_base,
  input  logic [AW-1:0] sp_base,
  input  logic [4:0]    rn,
  input  logic [6:0]    imm7,
  input  logic          dbl,
  output logic [AW-1:0] ea,
  output logic          sp_misalign
);

  localparam logic [4:0] SP_INDEX   = 5'd31;
  localparam int         ALIGN_BITS = 4;

  logic [AW-1:0] base;
  logic [AW-1:0] off_ext;
  logic [AW-1:0] off;
  logic          use_sp;

  always_comb begin
    use_sp      = (rn == SP_INDEX);
    base        = use_sp ? sp_base : gpr_base;
    off_ext     = {{(AW-7){imm7[6]}}, imm7};
    off         = dbl ? (off_ext << 3) : (off_ext << 2);
    ea          = base + off;
    sp_misalign = use_sp && (|sp_base[ALIGN_BITS-1:0]);
  end

endmodule

// File: rtl/lp_merge.sv
module lp_merge #(
  parameter int EW = 64
) (
  input  logic [2*EW-1:0] rsp,
  input  logic            dbl,
  input  logic            swap,
  output logic [EW-1:0]   elem_a,
  output logic [EW-1:0]   elem_b
);

  localparam int HW = EW / 2;

  logic [EW-1:0] lo;
  logic [EW-1:0] hi;

  always_comb begin
    lo     = dbl ? rsp[EW-1:0]      : {{HW{1'b0}}, rsp[HW-1:0]};
    hi     = dbl ? rsp[2*EW-1:EW]   : {{HW{1'b0}}, rsp[EW-1:HW]};
    elem_a = swap ? hi : lo;
    elem_b = swap ? lo : hi;
  end

endmodule

// File: rtl/lp_pair_unit.sv
module lp_pair_unit
  import lp_pkg::*;
#(
  parameter int         AW   = 64,
  parameter bit         WIDE = 1'b1,
  parameter logic [1:0] OVL  = OVL_ZERO
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_insn,
  input  logic            big_endian,
  output logic [4:0]      rf_rd_idx,
  input  logic [XLEN-1:0] rf_rd_data,
  input  logic [AW-1:0]   sp_value,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [AW-1:0]   mem_req_addr,
  output logic [2:0]      mem_req_size,
  output logic            mem_req_nt,
  input  logic            mem_rsp_valid,
  input  logic [2*XLEN-1:0] mem_rsp_data,
  input  logic            mem_rsp_err,
  output logic            wr0_en,
  output logic [4:0]      wr0_idx,
  output logic [XLEN-1:0] wr0_data,
  output logic            wr1_en,
  output logic [4:0]      wr1_idx,
  output logic [XLEN-1:0] wr1_data,
  output logic            exc_valid,
  output logic [1:0]      exc_code
);

  localparam int EW = XLEN;

  dec_t          dec;
  logic [AW-1:0] ea;
  logic          misalign;
  logic [EW-1:0] elem_a, elem_b;
  logic          same_dst;

  st_e           state_q, state_d;
  logic [AW-1:0] ea_q;
  logic          dbl_q, zero_q;
  logic [4:0]    rt_q, rt2_q;
  logic [EW-1:0] first_q, d0_q, d1_q;
  logic          wr_q, exc_q;
  exc_e          code_q;

  logic          ld_en, first_en, commit, exc_d;
  exc_e          code_d;
  logic [EW-1:0] data0_d, data1_d;
  logic [AW-1:0] step;

  lp_decode u_dec (.insn(in_insn), .dec(dec));

  lp_agen #(.AW(AW)) u_agen (
    .gpr_base   (rf_rd_data[AW-1:0]),
    .sp_base    (sp_value),
    .rn         (dec.rn),
    .imm7       (dec.imm7),
    .dbl        (dec.dbl),
    .ea         (ea),
    .sp_misalign(misalign)
  );

  lp_merge #(.EW(EW)) u_merge (
    .rsp   (mem_rsp_data),
    .dbl   (dbl_q),
    .swap  (big_endian && WIDE),
    .elem_a(elem_a),
    .elem_b(elem_b)
  );

  assign same_dst  = (dec.rt == dec.rt2);
  assign in_ready  = (state_q == ST_IDLE);
  assign rf_rd_idx = dec.rn;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    ld_en    = 1'b0;
    first_en = 1'b0;
    commit   = 1'b0;
    exc_d    = 1'b0;
    code_d   = EXC_NOMATCH;
    data0_d  = '0;
    data1_d  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          if (!dec.match) begin
            exc_d = 1'b1;
          end else if (dec.undef) begin
            exc_d  = 1'b1;
            code_d = EXC_UNDEF;
          end else if (same_dst && OVL == OVL_UNDEF) begin
            exc_d  = 1'b1;
            code_d = EXC_UNDEF;
          end else if (same_dst && OVL == OVL_NOP) begin
            exc_d = 1'b0;
          end else if (misalign) begin
            exc_d  = 1'b1;
            code_d = EXC_ALIGN;
          end else begin
            ld_en   = 1'b1;
            state_d = ST_REQ0;
          end
        end
      end
      ST_REQ0: if (mem_req_ready) state_d = ST_WAIT0;
      ST_WAIT0: begin
        if (mem_rsp_valid) begin
          state_d = ST_IDLE;
          if (mem_rsp_err) begin
            exc_d  = 1'b1;
            code_d = EXC_ABORT;
          end else if (WIDE) begin
            commit  = 1'b1;
            data0_d = elem_a;
            data1_d = elem_b;
          end else begin
            first_en = 1'b1;
            state_d  = ST_REQ1;
          end
        end
      end
      ST_REQ1: if (mem_req_ready) state_d = ST_WAIT1;
      ST_WAIT1: begin
        if (mem_rsp_valid) begin
          state_d = ST_IDLE;
          if (mem_rsp_err) begin
            exc_d  = 1'b1;
            code_d = EXC_ABORT;
          end else begin
            commit  = 1'b1;
            data0_d = first_q;
            data1_d = elem_a;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (zero_q) begin
      data0_d = '0;
      data1_d = '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ea_q    <= '0;
      dbl_q   <= 1'b0;
      zero_q  <= 1'b0;
      rt_q    <= '0;
      rt2_q   <= '0;
      first_q <= '0;
      d0_q    <= '0;
      d1_q    <= '0;
      wr_q    <= 1'b0;
      exc_q   <= 1'b0;
      code_q  <= EXC_NOMATCH;
    end else begin
      state_q <= state_d;
      wr_q    <= commit;
      exc_q   <= exc_d;
      if (exc_d) code_q <= code_d;
      if (ld_en) begin
        ea_q   <= ea;
        dbl_q  <= dec.dbl;
        zero_q <= same_dst;
        rt_q   <= dec.rt;
        rt2_q  <= dec.rt2;
      end
      if (first_en) first_q <= elem_a;
      if (commit) begin
        d0_q <= data0_d;
        d1_q <= data1_d;
      end
    end
  end

  assign step          = dbl_q ? AW'(8) : AW'(4);
  assign mem_req_valid = (state_q == ST_REQ0) || (state_q == ST_REQ1);
  assign mem_req_addr  = (state_q == ST_REQ1) ? (ea_q + step) : ea_q;
  assign mem_req_size  = WIDE ? (dbl_q ? 3'd4 : 3'd3) : (dbl_q ? 3'd3 : 3'd2);
  assign mem_req_nt    = 1'b1;

  assign wr0_en    = wr_q;
  assign wr1_en    = wr_q;
  assign wr0_idx   = rt_q;
  assign wr1_idx   = rt2_q;
  assign wr0_data  = d0_q;
  assign wr1_data  = d1_q;
  assign exc_valid = exc_q;
  assign exc_code  = code_q;

  // assertions
  p_nomatch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_insn[29:22] != 8'b1010_0001)
    |=> exc_valid && exc_code == 2'd0 && !mem_req_valid && !wr0_en);

  p_undef_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_insn[29:22] == 8'b1010_0001) && in_insn[30]
    |=> exc_valid && exc_code == 2'd1 && !mem_req_valid && !wr0_en);

  p_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_insn[29:22] == 8'b1010_0001) && !in_insn[30] &&
    (in_insn[9:5] == 5'd31) && (sp_value[3:0] != 4'd0) &&
    ((in_insn[4:0] != in_insn[14:10]) || OVL == 2'd0)
    |=> exc_valid && exc_code == 2'd2 && !mem_req_valid);

  p_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (OVL == 2'd2) && in_valid && in_ready && (in_insn[29:22] == 8'b1010_0001) &&
    !in_insn[30] && (in_insn[4:0] == in_insn[14:10])
    |=> !exc_valid && !mem_req_valid && !wr0_en);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_pair_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr0_en == wr1_en);

  p_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr0_en |-> $past(mem_rsp_valid && !mem_rsp_err));

  p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && mem_rsp_err && (state_q == ST_WAIT0 || state_q == ST_WAIT1)
    |=> exc_valid && exc_code == 2'd3 && !wr0_en && !mem_req_valid);

endmodule

// File: tb/sim_lp_pair_unit.sv
`timescale 1ns/1ps
module sim_lp_pair_unit;

  localparam int NI = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        in_valid = 1'b0;
  logic [31:0] in_insn = '0;
  logic        big_endian = 1'b0;
  logic [63:0] sp_value = '0;
  logic [63:0] rf_tab [32];

  logic         rdy   [NI];
  logic [4:0]   ridx  [NI];
  logic [63:0]  rdat  [NI];
  logic         reqv  [NI];
  logic [63:0]  reqa  [NI];
  logic [2:0]   reqs  [NI];
  logic         reqnt [NI];
  logic         rspv  [NI];
  logic [127:0] rspd  [NI];
  logic         rspe  [NI];
  logic         w0e [NI], w1e [NI];
  logic [4:0]   w0i [NI], w1i [NI];
  logic [63:0]  w0d [NI], w1d [NI];
  logic         excv [NI];
  logic [1:0]   excc [NI];

  int nreq [NI], nwr [NI], nexc [NI], latbad [NI], pairbad [NI], rsp_cyc [NI];
  logic [63:0] raddr [NI][4];
  logic [2:0]  rsize [NI][4];
  logic [63:0] lw0 [NI], lw1 [NI];
  logic [4:0]  lw0i [NI], lw1i [NI];
  logic [1:0]  lexc [NI];
  int s_req [NI], s_wr [NI], s_exc [NI], s_lat [NI], s_pair [NI];

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mb(input logic [63:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [127:0] mdata(input logic [63:0] a, input logic [2:0] sz);
    logic [127:0] r;
    r = '0;
    for (int k = 0; k < 16; k++)
      if (k < (1 << sz)) r[8*k +: 8] = mb(a + 64'(k));
    return r;
  endfunction

  function automatic logic [63:0] elem(input logic [63:0] a, input int n);
    logic [63:0] r;
    r = '0;
    for (int k = 0; k < n; k++) r[8*k +: 8] = mb(a + 64'(k));
    return r;
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] opc, input logic [6:0] imm,
                                     input logic [4:0] t2, input logic [4:0] n,
                                     input logic [4:0] t);
    return {opc, 8'b1010_0001, imm, t2, n, t};
  endfunction

  for (genvar gi = 0; gi < NI; gi++) begin : g
    assign rdat[gi] = rf_tab[ridx[gi]];

    lp_pair_unit #(.AW(64), .WIDE(gi == 0), .OVL(2'(gi))) u0 (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(rdy[gi]), .in_insn(in_insn),
      .big_endian(big_endian),
      .rf_rd_idx(ridx[gi]), .rf_rd_data(rdat[gi]), .sp_value(sp_value),
      .mem_req_valid(reqv[gi]), .mem_req_ready(1'b1), .mem_req_addr(reqa[gi]),
      .mem_req_size(reqs[gi]), .mem_req_nt(reqnt[gi]),
      .mem_rsp_valid(rspv[gi]), .mem_rsp_data(rspd[gi]), .mem_rsp_err(rspe[gi]),
      .wr0_en(w0e[gi]), .wr0_idx(w0i[gi]), .wr0_data(w0d[gi]),
      .wr1_en(w1e[gi]), .wr1_idx(w1i[gi]), .wr1_data(w1d[gi]),
      .exc_valid(excv[gi]), .exc_code(excc[gi])
    );

    logic        pend;
    logic [63:0] paddr;
    logic [2:0]  psize;

    initial begin
      pend = 1'b0; paddr = '0; psize = '0;
      rspv[gi] = 1'b0; rspd[gi] = '0; rspe[gi] = 1'b0;
      nreq[gi] = 0; nwr[gi] = 0; nexc[gi] = 0; latbad[gi] = 0; pairbad[gi] = 0;
      rsp_cyc[gi] = -1;
    end

    // monitor first, then memory responder (one-cycle latency)
    always @(negedge clk) begin
      if (rst_n) begin
        if (rspv[gi]) rsp_cyc[gi] = cyc;
        if (w0e[gi] != w1e[gi]) pairbad[gi]++;
        if (w0e[gi]) begin
          nwr[gi]++;
          lw0[gi] = w0d[gi]; lw1[gi] = w1d[gi];
          lw0i[gi] = w0i[gi]; lw1i[gi] = w1i[gi];
          if (rsp_cyc[gi] != cyc) latbad[gi]++;
        end
        if (excv[gi]) begin
          nexc[gi]++;
          lexc[gi] = excc[gi];
        end
        rspv[gi] = 1'b0;
        rspe[gi] = 1'b0;
        if (pend) begin
          rspv[gi] = 1'b1;
          rspd[gi] = mdata(paddr, psize);
          rspe[gi] = (paddr[39:32] == 8'hEE);
          pend = 1'b0;
        end
        if (reqv[gi]) begin
          pend = 1'b1; paddr = reqa[gi]; psize = reqs[gi];
          raddr[gi][nreq[gi] % 4] = reqa[gi];
          rsize[gi][nreq[gi] % 4] = reqs[gi];
          nreq[gi]++;
        end
      end
    end
  end

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic snap();
    for (int i = 0; i < NI; i++) begin
      s_req[i] = nreq[i]; s_wr[i] = nwr[i]; s_exc[i] = nexc[i];
      s_lat[i] = latbad[i]; s_pair[i] = pairbad[i];
    end
  endtask

  task automatic issue(input logic [31:0] w);
    snap();
    @(negedge clk);
    in_valid = 1'b1;
    in_insn  = w;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (10) @(negedge clk);
    for (int i = 0; i < NI; i++) chk("R11 unit idle after op", 64'(rdy[i]), 64'd1);
  endtask

  task automatic chk_exc(input int i, input logic [1:0] code, input string rq);
    chk({rq, " exception count"}, 64'(nexc[i] - s_exc[i]), 64'd1);
    chk({rq, " exception code"}, 64'(lexc[i]), 64'(code));
    chk({rq, " no memory request"}, 64'(nreq[i] - s_req[i]), 64'd0);
    chk({rq, " no write"}, 64'(nwr[i] - s_wr[i]), 64'd0);
  endtask

  task automatic chk_load(input int i, input logic [63:0] ea, input bit dbl, input bit be,
                          input logic [4:0] t, input logic [4:0] t2, input string rq);
    int n;
    logic [63:0] e0, e1;
    n  = dbl ? 8 : 4;
    e0 = elem(ea, n);
    e1 = elem(ea + 64'(n), n);
    if (i == 0) begin
      chk({rq, " R7 one wide request"}, 64'(nreq[i] - s_req[i]), 64'd1);
      chk({rq, " R3 R7 request address"}, raddr[i][s_req[i] % 4], ea);
      chk({rq, " R7 request size"}, 64'(rsize[i][s_req[i] % 4]), dbl ? 64'd4 : 64'd3);
      chk({rq, " R7 R8 port0 data"}, lw0[i], be ? e1 : e0);
      chk({rq, " R7 R8 port1 data"}, lw1[i], be ? e0 : e1);
    end else begin
      chk({rq, " R9 two requests"}, 64'(nreq[i] - s_req[i]), 64'd2);
      chk({rq, " R3 R9 first address"}, raddr[i][s_req[i] % 4], ea);
      chk({rq, " R9 second address"}, raddr[i][(s_req[i] + 1) % 4], ea + 64'(n));
      chk({rq, " R9 size"}, 64'(rsize[i][s_req[i] % 4]), dbl ? 64'd3 : 64'd2);
      chk({rq, " R9 port0 data"}, lw0[i], e0);
      chk({rq, " R9 port1 data"}, lw1[i], e1);
    end
    chk({rq, " R11 one commit"}, 64'(nwr[i] - s_wr[i]), 64'd1);
    chk({rq, " R11 commit right after response"}, 64'(latbad[i] - s_lat[i]), 64'd0);
    chk({rq, " R11 paired enables"}, 64'(pairbad[i] - s_pair[i]), 64'd0);
    chk({rq, " R7 port indices"}, {54'd0, lw0i[i], lw1i[i]}, {54'd0, t, t2});
    chk({rq, " no exception"}, 64'(nexc[i] - s_exc[i]), 64'd0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NI; i++) begin
      chk("R11 reset ready", 64'(rdy[i]), 64'd1);
      chk("R11 reset no write", 64'(w0e[i] | w1e[i]), 64'd0);
      chk("R12 reset no exception", 64'(excv[i]), 64'd0);
      chk("R9 reset no request", 64'(reqv[i]), 64'd0);
    end
  endtask

  task automatic t_nomatch();
    issue(mk(2'b00, 7'd1, 5'd2, 5'd5, 5'd1) ^ 32'h0040_0000);
    for (int i = 0; i < NI; i++) chk_exc(i, 2'd0, "R1 mismatch");
  endtask

  task automatic t_undef();
    issue(mk(2'b01, 7'd1, 5'd2, 5'd5, 5'd1));
    for (int i = 0; i < NI; i++) chk_exc(i, 2'd1, "R2 reserved size");
  endtask

  task automatic t_load32();
    rf_tab[5] = 64'h0000_0000_0000_1000;
    big_endian = 1'b0;
    issue(mk(2'b00, 7'h7D, 5'd2, 5'd5, 5'd1));
    for (int i = 0; i < NI; i++)
      chk_load(i, 64'h0FF4, 1'b0, 1'b0, 5'd1, 5'd2, "R3 R4 R10 32-bit LE");
    for (int i = 0; i < NI; i++) begin
      chk("R10 zero-extended port0", {32'd0, lw0[i][63:32]}, 64'd0);
      chk("R10 zero-extended port1", {32'd0, lw1[i][63:32]}, 64'd0);
    end
  endtask

  task automatic t_load64_be();
    rf_tab[7] = 64'h0000_0012_3456_7800;
    big_endian = 1'b1;
    issue(mk(2'b10, 7'd63, 5'd9, 5'd7, 5'd8));
    for (int i = 0; i < NI; i++)
      chk_load(i, 64'h0000_0012_3456_79F8, 1'b1, 1'b1, 5'd8, 5'd9, "R8 64-bit BE");
    big_endian = 1'b0;
  endtask

  task automatic t_sp();
    rf_tab[31] = 64'hDEAD_0000_0000_0000;
    sp_value   = 64'h0000_0000_0000_2000;
    issue(mk(2'b10, 7'h40, 5'd4, 5'd31, 5'd6));
    for (int i = 0; i < NI; i++)
      chk_load(i, 64'h1E00, 1'b1, 1'b0, 5'd6, 5'd4, "R4 stack pointer base");
    sp_value = 64'h0000_0000_0000_2008;
    issue(mk(2'b10, 7'h40, 5'd4, 5'd31, 5'd6));
    for (int i = 0; i < NI; i++) chk_exc(i, 2'd2, "R5 misaligned stack pointer");
    sp_value = 64'h0000_0000_0000_2000;
  endtask

  task automatic t_overlap();
    rf_tab[4] = 64'h0000_0000_0000_3000;
    issue(mk(2'b10, 7'd1, 5'd3, 5'd4, 5'd3));
    chk("R6 zero policy one request", 64'(nreq[0] - s_req[0]), 64'd1);
    chk("R6 zero policy commit", 64'(nwr[0] - s_wr[0]), 64'd1);
    chk("R6 zero policy port0 zero", lw0[0], 64'd0);
    chk("R6 zero policy port1 zero", lw1[0], 64'd0);
    chk_exc(1, 2'd1, "R6 undefined policy");
    chk("R6 nop policy no request", 64'(nreq[2] - s_req[2]), 64'd0);
    chk("R6 nop policy no write", 64'(nwr[2] - s_wr[2]), 64'd0);
    chk("R6 nop policy no exception", 64'(nexc[2] - s_exc[2]), 64'd0);
  endtask

  task automatic t_abort_first();
    rf_tab[9] = 64'h0000_00EE_0000_0100;
    issue(mk(2'b10, 7'd0, 5'd11, 5'd9, 5'd10));
    for (int i = 0; i < NI; i++) begin
      chk("R12 abort count", 64'(nexc[i] - s_exc[i]), 64'd1);
      chk("R12 abort code", 64'(lexc[i]), 64'd3);
      chk("R12 abort no write", 64'(nwr[i] - s_wr[i]), 64'd0);
      chk("R12 single request", 64'(nreq[i] - s_req[i]), 64'd1);
    end
  endtask

  task automatic t_abort_second();
    rf_tab[10] = 64'h0000_00ED_FFFF_FFFC;
    issue(mk(2'b00, 7'd0, 5'd13, 5'd10, 5'd12));
    chk_load(0, 64'h0000_00ED_FFFF_FFFC, 1'b0, 1'b0, 5'd12, 5'd13, "R12 wide unaffected");
    for (int i = 1; i < NI; i++) begin
      chk("R12 second-read error two requests", 64'(nreq[i] - s_req[i]), 64'd2);
      chk("R12 second-read abort", 64'(nexc[i] - s_exc[i]), 64'd1);
      chk("R12 second-read abort code", 64'(lexc[i]), 64'd3);
      chk("R12 second-read no write", 64'(nwr[i] - s_wr[i]), 64'd0);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int k = 0; k < 32; k++) rf_tab[k] = 64'(k) << 12;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_nomatch();
    t_undef();
    t_load32();
    t_load64_be();
    t_sp();
    t_overlap();
    t_abort_first();
    t_abort_second();
    summary();
  end

endmodule